// File: doc/BRIEF.md
# Platform System Control Register File

This block is a byte-wide bank of control and status ports on a small computer's I/O bus. A bus master issues single-cycle read or write strobes with a port address and, for writes, one data byte. Writes to control ports update level outputs held in registers: a soft-reset request, a little-endian mode flag, a disk-activity lamp, a 4-bit system control field and an I/O map type select. Writes to either of two lock ports emit a one-cycle pulse that toggles an external NVRAM write lock.

Reads return either live register state or fixed identification and equipment codes. Read data is registered and stays on the bus until the next read strobe. Some ports are read-only identity ports. Writes to them change nothing. Any access to a port that the block does not decode, in the direction of that access, returns all ones for a read and raises a one-cycle error strobe.

Top module: `sysctl_regfile`

## Requirements
- R1: While rst_n is low, every output is 0: soft_reset_o, little_endian_o, lamp_o, sysctl_o, iomap_o, both lock pulses, decode_err_o, and rd_data (0x00).
- R2: A write to port 0x0092 sets soft_reset_o from data bit 0 and little_endian_o from data bit 1, from the cycle after the strobe. A read of 0x0092 returns the endian flag in bit 1 and 0 in every other bit.
- R3: Ports 0x0800, 0x0802 and 0x0803 read as 0xEF, 0xAD and 0xE0. A write to any of them changes no output, does not change later reads, and raises no error.
- R4: A write to port 0x0808 sets lamp_o from data bit 0. A read of 0x0808 is treated as undecoded.
- R5: A write to port 0x0810 makes lock1_pulse_o high for exactly one cycle, the cycle after the strobe. A write to 0x0812 does the same on lock2_pulse_o. The data byte is ignored, and only one pulse is high at a time.
- R6: A write to port 0x081C stores data bits 3:0 on sysctl_o. A read of 0x081C returns {4'b0, sysctl_o}.
- R7: A write to port 0x0850 stores data bit 0 on iomap_o. A read of 0x0850 returns {7'b0, iomap_o}.
- R8: Port 0x080C reads as 0x3C, 0x0810 as 0x39, 0x0818 as 0x00 and 0x0823 as 0x03. Port 0x0814 accepts writes with no effect and reads as 0xFF, without error in either direction.
- R9: A read of an undecoded port returns 0xFF. Any read or write of a port not decoded for that direction pulses decode_err_o high for one cycle after the strobe. A decoded access never raises it.
- R10: rd_data changes only in the cycle after a read strobe and otherwise holds its last value.
- R11: When a read and a write of the same port fall in the same cycle, the read returns the value from before the write, and the write takes effect as usual.
- R12: Control state changes only in the cycle after a write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Port address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data, valid the cycle after bus_rd |
| soft_reset_o | output | 1 | Soft-reset request level |
| little_endian_o | output | 1 | Little-endian mode flag |
| lamp_o | output | 1 | Disk-activity lamp |
| lock1_pulse_o | output | 1 | One-cycle toggle pulse for NVRAM lock 1 |
| lock2_pulse_o | output | 1 | One-cycle toggle pulse for NVRAM lock 2 |
| sysctl_o | output | 4 | System control field |
| iomap_o | output | 1 | I/O map type select |
| decode_err_o | output | 1 | One-cycle strobe for an undecoded access |

## Verification
The read path and the write path can act on the same port in one cycle. The bench provokes this by raising both strobes at port 0x0850 and at port 0x0092 while the new value differs from the stored one. It judges the result by requiring that rd_data shows the value from before the write, while iomap_o or little_endian_o shows the new value in the same sampled cycle. Port 0x0810 is also struck with both strobes together. There the fixed code 0x39 must come back and the lock pulse must still fire, with no error strobe.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned CTRL_W  = 4;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned N_LOCKS = 2;

    // Port addresses; software depends on these exact values.
    localparam logic [15:0] A_SPECIAL = 16'h0092;
    localparam logic [15:0] A_CPUCFG  = 16'h0800;
    localparam logic [15:0] A_FEATURE = 16'h0802;
    localparam logic [15:0] A_MODSTAT = 16'h0803;
    localparam logic [15:0] A_LAMP    = 16'h0808;
    localparam logic [15:0] A_EQUIP   = 16'h080C;
    localparam logic [15:0] A_LOCK1   = 16'h0810;
    localparam logic [15:0] A_LOCK2   = 16'h0812;
    localparam logic [15:0] A_CACHEIV = 16'h0814;
    localparam logic [15:0] A_KEYSW   = 16'h0818;
    localparam logic [15:0] A_CTRL    = 16'h081C;
    localparam logic [15:0] A_CACHEST = 16'h0823;
    localparam logic [15:0] A_MAPSEL  = 16'h0850;

    typedef enum logic [3:0] {
        PID_NONE,
        PID_SPECIAL,
        PID_CPUCFG,
        PID_FEATURE,
        PID_MODSTAT,
        PID_LAMP,
        PID_EQUIP,
        PID_LOCK1,
        PID_LOCK2,
        PID_CACHEIV,
        PID_KEYSW,
        PID_CTRL,
        PID_CACHEST,
        PID_MAPSEL
    } port_id_e;

    typedef struct packed {
        logic                soft_rst;
        logic                little_end;
        logic                lamp;
        logic [CTRL_W-1:0]   ctrl;
        logic                map_type;
        logic [N_LOCKS-1:0]  lock_pulse;
        logic                err;
    } ctl_state_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output port_id_e          pid,
    output logic              rd_ok,
    output logic              wr_ok
);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [15:0] p);
        return a == ADDR_W'(p);
    endfunction

    always_comb begin
        pid = PID_NONE;
        if      (hit(addr, A_SPECIAL)) pid = PID_SPECIAL;
        else if (hit(addr, A_CPUCFG))  pid = PID_CPUCFG;
        else if (hit(addr, A_FEATURE)) pid = PID_FEATURE;
        else if (hit(addr, A_MODSTAT)) pid = PID_MODSTAT;
        else if (hit(addr, A_LAMP))    pid = PID_LAMP;
        else if (hit(addr, A_EQUIP))   pid = PID_EQUIP;
        else if (hit(addr, A_LOCK1))   pid = PID_LOCK1;
        else if (hit(addr, A_LOCK2))   pid = PID_LOCK2;
        else if (hit(addr, A_CACHEIV)) pid = PID_CACHEIV;
        else if (hit(addr, A_KEYSW))   pid = PID_KEYSW;
        else if (hit(addr, A_CTRL))    pid = PID_CTRL;
        else if (hit(addr, A_CACHEST)) pid = PID_CACHEST;
        else if (hit(addr, A_MAPSEL))  pid = PID_MAPSEL;
    end

    // Direction-specific decode: some ports exist only for reads or only for writes.
    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        unique case (pid)
            PID_SPECIAL, PID_CPUCFG, PID_FEATURE, PID_MODSTAT,
            PID_LOCK1, PID_CACHEIV, PID_CTRL, PID_MAPSEL: begin
                rd_ok = 1'b1;
                wr_ok = 1'b1;
            end
            PID_EQUIP, PID_KEYSW, PID_CACHEST: rd_ok = 1'b1;
            PID_LAMP, PID_LOCK2:               wr_ok = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sysctl_state.sv
module sysctl_state
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  port_id_e          pid,
    input  logic              rd_ok,
    input  logic              wr_ok,
    output ctl_state_t        st
);

    localparam port_id_e LOCK_IDS [N_LOCKS] = '{PID_LOCK1, PID_LOCK2};

    ctl_state_t         st_d, st_q;
    logic [N_LOCKS-1:0] lock_hit;

    for (genvar g = 0; g < N_LOCKS; g++) begin : g_lock
        assign lock_hit[g] = wr && (pid == LOCK_IDS[g]);
    end

    always_comb begin
        st_d            = st_q;
        st_d.lock_pulse = lock_hit;
        st_d.err        = (rd && !rd_ok) || (wr && !wr_ok);
        if (wr) begin
            unique case (pid)
                PID_SPECIAL: begin
                    st_d.soft_rst   = wdata[0];
                    st_d.little_end = wdata[1];
                end
                PID_LAMP:   st_d.lamp     = wdata[0];
                PID_CTRL:   st_d.ctrl     = wdata[CTRL_W-1:0];
                PID_MAPSEL: st_d.map_type = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    // R5
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.lock_pulse) |-> $past(wr));

    // R5
    lock_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.lock_pulse));

    // R12
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr) |-> $stable({st_q.soft_rst, st_q.little_end, st_q.lamp,
                                st_q.ctrl, st_q.map_type}));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> $past(rd || wr));

endmodule

// File: rtl/sysctl_readmux.sv
module sysctl_readmux
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] CPUCFG_CODE  = 8'hEF,
    parameter logic [DATA_W-1:0] FEATURE_CODE = 8'hAD,
    parameter logic [DATA_W-1:0] MODSTAT_CODE = 8'hE0,
    parameter logic [DATA_W-1:0] EQUIP_CODE   = 8'h3C,
    parameter logic [DATA_W-1:0] EXTFEAT_CODE = 8'h39,
    parameter logic [DATA_W-1:0] KEYSW_CODE   = 8'h00,
    parameter logic [DATA_W-1:0] CACHEST_CODE = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  port_id_e          pid,
    input  logic              rd_ok,
    input  ctl_state_t        st,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd) begin
            unique case (pid)
                PID_SPECIAL: rdata_d = DATA_W'({st.little_end, 1'b0});
                PID_CPUCFG:  rdata_d = CPUCFG_CODE;
                PID_FEATURE: rdata_d = FEATURE_CODE;
                PID_MODSTAT: rdata_d = MODSTAT_CODE;
                PID_EQUIP:   rdata_d = EQUIP_CODE;
                PID_LOCK1:   rdata_d = EXTFEAT_CODE;
                PID_KEYSW:   rdata_d = KEYSW_CODE;
                PID_CTRL:    rdata_d = DATA_W'(st.ctrl);
                PID_CACHEST: rdata_d = CACHEST_CODE;
                PID_MAPSEL:  rdata_d = DATA_W'(st.map_type);
                default:     rdata_d = ALL_ONES;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd) |-> $stable(rdata_q));

    // R9
    undecoded_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd && !rd_ok) |-> (rdata_q == ALL_ONES));

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rd_data,
    output logic              soft_reset_o,
    output logic              little_endian_o,
    output logic              lamp_o,
    output logic              lock1_pulse_o,
    output logic              lock2_pulse_o,
    output logic [3:0]        sysctl_o,
    output logic              iomap_o,
    output logic              decode_err_o
);

    port_id_e   pid;
    logic       rd_ok, wr_ok;
    ctl_state_t st;

    sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (bus_addr),
        .pid   (pid),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok)
    );

    sysctl_state u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .pid   (pid),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok),
        .st    (st)
    );

    sysctl_readmux u_readmux (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .pid   (pid),
        .rd_ok (rd_ok),
        .st    (st),
        .rdata (rd_data)
    );

    assign soft_reset_o    = st.soft_rst;
    assign little_endian_o = st.little_end;
    assign lamp_o          = st.lamp;
    assign lock1_pulse_o   = st.lock_pulse[0];
    assign lock2_pulse_o   = st.lock_pulse[1];
    assign sysctl_o        = st.ctrl;
    assign iomap_o         = st.map_type;
    assign decode_err_o    = st.err;

endmodule

// File: tb/tb_sysctl_regfile.sv
`timescale 1ns/1ps
module tb_sysctl_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data;
    logic        soft_reset_o, little_endian_o, lamp_o;
    logic        lock1_pulse_o, lock2_pulse_o, iomap_o, decode_err_o;
    logic [3:0]  sysctl_o;

    int n_checks = 0;
    int n_fail   = 0;

    // Values captured one cycle after each access
    logic [7:0] got_rd;
    logic       got_err, got_l1, got_l2;

    always #2 clk = ~clk;

    sysctl_regfile dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .soft_reset_o(soft_reset_o), .little_endian_o(little_endian_o),
        .lamp_o(lamp_o), .lock1_pulse_o(lock1_pulse_o),
        .lock2_pulse_o(lock2_pulse_o), .sysctl_o(sysctl_o),
        .iomap_o(iomap_o), .decode_err_o(decode_err_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic access(input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_rd = rd; bus_wr = wr;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        got_rd = rd_data; got_err = decode_err_o;
        got_l1 = lock1_pulse_o; got_l2 = lock2_pulse_o;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        access(1'b0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [15:0] a);
        access(1'b1, 1'b0, a, 8'h00);
    endtask

    function automatic logic [31:0] all_outs();
        return {rd_data, soft_reset_o, little_endian_o, lamp_o, lock1_pulse_o,
                lock2_pulse_o, sysctl_o, iomap_o, decode_err_o};
    endfunction

    task automatic t_reset_state();
        check("R1 reset outputs", all_outs(), 32'h0);
    endtask

    task automatic t_special();
        wr(16'h0092, 8'h03);
        check("R2 soft reset set", soft_reset_o, 1);
        check("R2 endian set", little_endian_o, 1);
        check("R9 no err on decoded write", got_err, 0);
        rd(16'h0092);
        check("R2 read endian", got_rd, 8'h02);
        wr(16'h0092, 8'hFD);
        check("R2 soft reset bit0", soft_reset_o, 1);
        check("R2 endian bit1 clear", little_endian_o, 0);
        rd(16'h0092);
        check("R2 read zero", got_rd, 8'h00);
        wr(16'h0092, 8'h00);
        check("R2 soft reset released", soft_reset_o, 0);
    endtask

    task automatic t_ident();
        rd(16'h0800); check("R3 cpu cfg", got_rd, 8'hEF);
        rd(16'h0802); check("R3 feature", got_rd, 8'hAD);
        rd(16'h0803); check("R3 module status", got_rd, 8'hE0);
        wr(16'h081C, 8'h06);
        wr(16'h0800, 8'h00);
        check("R3 write no err", got_err, 0);
        wr(16'h0802, 8'hFF);
        wr(16'h0803, 8'h5A);
        check("R3 outputs unchanged", {soft_reset_o, little_endian_o, lamp_o, sysctl_o, iomap_o}, 32'h0C);
        rd(16'h0800); check("R3 cpu cfg after write", got_rd, 8'hEF);
        rd(16'h0803); check("R3 status after write", got_rd, 8'hE0);
    endtask

    task automatic t_lamp();
        wr(16'h0808, 8'h01); check("R4 lamp on", lamp_o, 1);
        wr(16'h0808, 8'hFE); check("R4 lamp off", lamp_o, 0);
        rd(16'h0808);
        check("R4 lamp read all ones", got_rd, 8'hFF);
        check("R4 lamp read err", got_err, 1);
    endtask

    task automatic t_locks();
        wr(16'h0810, 8'hA7);
        check("R5 lock1 pulse", {got_l1, got_l2}, 2'b10);
        @(negedge clk);
        check("R5 lock1 single cycle", lock1_pulse_o, 0);
        wr(16'h0812, 8'h00);
        check("R5 lock2 pulse", {got_l1, got_l2}, 2'b01);
        check("R5 lock2 no err", got_err, 0);
        @(negedge clk);
        check("R5 lock2 single cycle", lock2_pulse_o, 0);
    endtask

    task automatic t_ctrl();
        wr(16'h081C, 8'hA5);
        check("R6 ctrl low nibble", sysctl_o, 4'h5);
        rd(16'h081C);
        check("R6 ctrl read", got_rd, 8'h05);
        wr(16'h081C, 8'hFA);
        rd(16'h081C);
        check("R6 ctrl read 2", got_rd, 8'h0A);
    endtask

    task automatic t_map();
        wr(16'h0850, 8'hFF);
        check("R7 map set", iomap_o, 1);
        rd(16'h0850); check("R7 map read 1", got_rd, 8'h01);
        wr(16'h0850, 8'hFE);
        check("R7 map clear", iomap_o, 0);
        rd(16'h0850); check("R7 map read 0", got_rd, 8'h00);
    endtask

    task automatic t_fixed();
        rd(16'h080C); check("R8 equip", got_rd, 8'h3C);
        rd(16'h0810); check("R8 ext feature", got_rd, 8'h39);
        check("R8 ext feature read no pulse", got_l1, 0);
        rd(16'h0818); check("R8 keyswitch", got_rd, 8'h00);
        rd(16'h0823); check("R8 cache status", got_rd, 8'h03);
        wr(16'h0814, 8'hFF);
        check("R8 cache inval write no err", got_err, 0);
        check("R8 cache inval no effect", {soft_reset_o, little_endian_o, lamp_o, sysctl_o, iomap_o}, 32'h14);
        rd(16'h0814);
        check("R8 cache inval read", got_rd, 8'hFF);
        check("R8 cache inval read no err", got_err, 0);
    endtask

    task automatic t_undecoded();
        rd(16'h0900);
        check("R9 undecoded read ones", got_rd, 8'hFF);
        check("R9 undecoded read err", got_err, 1);
        @(negedge clk);
        check("R9 err single cycle", decode_err_o, 0);
        wr(16'h0801, 8'h01);
        check("R9 undecoded write err", got_err, 1);
        wr(16'h080C, 8'h00);
        check("R9 write to read-only-decode port err", got_err, 1);
        rd(16'h0812);
        check("R9 lock2 read ones", got_rd, 8'hFF);
        check("R9 lock2 read err", got_err, 1);
        rd(16'h0823);
        check("R9 decoded read no err", got_err, 0);
    endtask

    task automatic t_hold();
        rd(16'h0802);
        wr(16'h0850, 8'h01);
        repeat (3) @(negedge clk);
        check("R10 read data held", rd_data, 8'hAD);
    endtask

    task automatic t_same_cycle();
        // iomap_o is 1 from t_hold
        access(1'b1, 1'b1, 16'h0850, 8'h00);
        check("R11 read old map", got_rd, 8'h01);
        check("R11 map written", iomap_o, 0);
        wr(16'h0092, 8'h02);
        access(1'b1, 1'b1, 16'h0092, 8'h00);
        check("R11 read old endian", got_rd, 8'h02);
        check("R11 endian written", little_endian_o, 0);
        access(1'b1, 1'b1, 16'h0810, 8'h00);
        check("R11 lock1 read code", got_rd, 8'h39);
        check("R11 lock1 pulse", got_l1, 1);
        check("R11 no err", got_err, 0);
    endtask

    task automatic t_mid_reset();
        wr(16'h0092, 8'h03);
        wr(16'h081C, 8'h0F);
        wr(16'h0808, 8'h01);
        rd(16'h0800);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset clears state", all_outs(), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_special();
        t_ident();
        t_lamp();
        t_locks();
        t_ctrl();
        t_map();
        t_fixed();
        t_undecoded();
        t_hold();
        t_same_cycle();
        t_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule